// File: doc/BRIEF.md
# Retriggerable One-Shot Pulse Generator

This block is a clocked, retriggerable monostable. It watches two trigger inputs, one that fires on a falling edge and one that fires on a rising edge. Each trigger input is qualified by the level of the other and by an active-low clear. When a valid trigger is seen, the output goes high for a run-time number of clock cycles. A further valid trigger during the pulse restarts the full count. Holding the clear low ends any pulse at once.

All three control inputs are treated as asynchronous. Each one passes through a two-flop synchroniser, and edges are judged on the synchronised levels. Two timing rules shape which edges count. Two accepted triggers must be at least a minimum number of cycles apart. After the clear is released, trigger edges are ignored for a set number of cycles.

A build-time mode sets whether releasing the clear can itself start a pulse. In the firing mode, a rising clear starts a pulse when the falling-edge input is low and the rising-edge input is high.

Top module: `oneshot_retrig`

## Requirements
- R1: A falling edge on `trig_a` (synchronised) starts or restarts the pulse only while `trig_b` is high and `clr_n` is high.
- R2: A rising edge on `trig_b` starts or restarts the pulse only while `trig_a` is low and `clr_n` is high. A rising edge on `trig_b` while `trig_a` is high does nothing.
- R3: While the synchronised `clr_n` is low, `q` is low and any running pulse is cancelled. Trigger edges that arrive during that time are ignored.
- R4: With `REL_MODE = REL_FIRES`, a rising edge on `clr_n` while `trig_a` is low and `trig_b` is high starts a pulse. With `REL_MODE = REL_SILENT`, releasing `clr_n` never starts a pulse.
- R5: An accepted trigger loads the value on `width`. `q` then stays high for exactly that many cycles, counted from the most recent accepted trigger.
- R6: A trigger is accepted only if it comes at least `MIN_GAP` cycles after the previous accepted trigger. Closer triggers change nothing.
- R7: Static levels and non-qualifying changes keep the outputs idle: `q` = 0 and `q_n` = 1. Examples are `trig_a` rising, `trig_b` falling, and `trig_b` rising while `trig_a` is high.
- R8: `q_n` is always the exact complement of `q`.
- R9: A trigger accepted while `width` is 0 produces no pulse. A `width` of 1 produces a single-cycle pulse.
- R10: Latency: when an input changes just before clock edge k and forms a valid trigger, `q` becomes high after edge k+2.
- R11: While the synchronous `rst` is high, `q` is 0 and `q_n` is 1, and all internal timing is cleared.
- R12: After the synchronised `clr_n` rises, edges on `trig_a` and `trig_b` are ignored for `REM_DLY` cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_a | input | 1 | Trigger input, fires on a falling edge |
| trig_b | input | 1 | Trigger input, fires on a rising edge |
| clr_n | input | 1 | Active-low clear, overrides the pulse |
| width | input | WIDTH_W | Pulse length in clock cycles, sampled on each accepted trigger |
| q | output | 1 | Pulse output, active high |
| q_n | output | 1 | Complement of `q` |

## Verification
The assertions are checked on every cycle. They cover these points: the clear empties the width counter by the next cycle, an accepted trigger loads the requested width, the counter steps down by exactly one per cycle, two accepted triggers never fall on adjacent cycles, and in the silent mode a rising clear never fires. The bench scenarios are needed to show the rest. These are the qualification of each input by the other, the exact pulse length and the extension by a later trigger, and rejection of a retrigger that comes too soon. They also cover the blind window after the clear is released, and the different outcomes of the two build-time modes when the clear is released under the same input levels.

// File: rtl/oneshot_pkg.sv
package oneshot_pkg;

    // Behaviour on release of the clear input
    typedef enum logic {
        REL_SILENT = 1'b0,
        REL_FIRES  = 1'b1
    } rel_mode_e;

    // Synchronised levels of the three control inputs
    typedef struct packed {
        logic a;
        logic b;
        logic r;
    } trig_lvl_t;

    // Quiet level set used for reset of the synchroniser and edge history
    localparam trig_lvl_t IDLE_LVL = '{a: 1'b1, b: 1'b0, r: 1'b1};

    localparam int SYNC_STAGES = 2;
    localparam int TICK_W      = 16;

    typedef logic [TICK_W-1:0] tick_t;

    function automatic tick_t tick_dec(input tick_t v);
        return (v == '0) ? '0 : v - tick_t'(1);
    endfunction

endpackage

// File: rtl/os_sync.sv
module os_sync
    import oneshot_pkg::*;
#(
    parameter int        STAGES  = SYNC_STAGES,
    parameter trig_lvl_t RST_VAL = IDLE_LVL
) (
    input  logic      clk,
    input  logic      rst,
    input  trig_lvl_t d,
    output trig_lvl_t q
);

    trig_lvl_t stage [STAGES];

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stage[i] <= RST_VAL;
                else     stage[i] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stage[i] <= RST_VAL;
                else     stage[i] <= stage[i-1];
            end
        end
    end

    assign q = stage[STAGES-1];

endmodule

// File: rtl/os_qual.sv
module os_qual
    import oneshot_pkg::*;
#(
    parameter int        MIN_GAP  = 4,
    parameter int        REM_DLY  = 3,
    parameter rel_mode_e REL_MODE = REL_FIRES
) (
    input  logic      clk,
    input  logic      rst,
    input  trig_lvl_t lvl,
    output logic      fire
);

    localparam tick_t GAP_LOAD = (MIN_GAP > 0) ? tick_t'(MIN_GAP - 1) : '0;
    localparam tick_t REM_LOAD = tick_t'(REM_DLY);

    trig_lvl_t prev_q;
    tick_t     gap_q;
    tick_t     rem_q;
    logic      a_fall_ok;
    logic      b_rise_ok;
    logic      rel_edge;
    logic      cand;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= IDLE_LVL;
        else     prev_q <= lvl;
    end

    // Qualified edges on the two trigger inputs
    assign a_fall_ok = prev_q.a & ~lvl.a &  lvl.b & lvl.r;
    assign b_rise_ok = ~prev_q.b & lvl.b & ~lvl.a & lvl.r;

    // Optional start on release of the clear
    if (REL_MODE == REL_FIRES) begin : g_rel_fire
        assign rel_edge = ~prev_q.r & lvl.r & ~lvl.a & lvl.b;
    end else begin : g_rel_quiet
        assign rel_edge = 1'b0;
    end

    // Blind window after the clear is released
    always_ff @(posedge clk) begin
        if (rst)         rem_q <= '0;
        else if (!lvl.r) rem_q <= REM_LOAD;
        else             rem_q <= tick_dec(rem_q);
    end

    assign cand = rel_edge | ((rem_q == '0) & (a_fall_ok | b_rise_ok));
    assign fire = cand & (gap_q == '0);

    // Minimum spacing between accepted triggers
    always_ff @(posedge clk) begin
        if (rst)       gap_q <= '0;
        else if (fire) gap_q <= GAP_LOAD;
        else           gap_q <= tick_dec(gap_q);
    end

    if (MIN_GAP >= 2) begin : g_gap_chk
        p_spacing_r6: assert property (@(posedge clk) disable iff (rst)
            fire |=> !fire)
            else $error("two accepted triggers on adjacent cycles");
    end

endmodule

// File: rtl/os_width_ctr.sv
module os_width_ctr #(
    parameter int WIDTH_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               run,
    input  logic               load,
    input  logic [WIDTH_W-1:0] width,
    output logic               active
);

    logic [WIDTH_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)                cnt_q <= '0;
        else if (!run)          cnt_q <= '0;
        else if (load)          cnt_q <= width;
        else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
    end

    assign active = (cnt_q != '0);

    p_reload_r5: assert property (@(posedge clk) disable iff (rst)
        (run && load) |=> (cnt_q == $past(width)))
        else $error("accepted trigger did not load the width");

    p_count_r5: assert property (@(posedge clk) disable iff (rst)
        (run && !load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1))
        else $error("width counter did not step by one");

endmodule

// File: rtl/oneshot_retrig.sv
module oneshot_retrig
    import oneshot_pkg::*;
#(
    parameter int        WIDTH_W  = 8,
    parameter int        MIN_GAP  = 4,
    parameter int        REM_DLY  = 3,
    parameter rel_mode_e REL_MODE = REL_FIRES
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               trig_a,
    input  logic               trig_b,
    input  logic               clr_n,
    input  logic [WIDTH_W-1:0] width,
    output logic               q,
    output logic               q_n
);

    trig_lvl_t raw_lvl;
    trig_lvl_t lvl;
    logic      fire;
    logic      active;

    assign raw_lvl = '{a: trig_a, b: trig_b, r: clr_n};

    os_sync #(
        .STAGES  (SYNC_STAGES),
        .RST_VAL (IDLE_LVL)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw_lvl),
        .q   (lvl)
    );

    os_qual #(
        .MIN_GAP  (MIN_GAP),
        .REM_DLY  (REM_DLY),
        .REL_MODE (REL_MODE)
    ) u_qual (
        .clk  (clk),
        .rst  (rst),
        .lvl  (lvl),
        .fire (fire)
    );

    os_width_ctr #(
        .WIDTH_W (WIDTH_W)
    ) u_width (
        .clk    (clk),
        .rst    (rst),
        .run    (lvl.r),
        .load   (fire),
        .width  (width),
        .active (active)
    );

    // The clear gates the output directly, one cycle ahead of the counter flush
    assign q   = active & lvl.r;
    assign q_n = ~q;

    p_clear_r3: assert property (@(posedge clk) disable iff (rst)
        !lvl.r |=> !q)
        else $error("pulse survived a low clear");

    if (REL_MODE == REL_SILENT && REM_DLY > 0) begin : g_silent_chk
        p_norelfire_r4: assert property (@(posedge clk) disable iff (rst)
            $rose(lvl.r) |-> !fire)
            else $error("release of clear started a pulse in silent mode");
    end

endmodule

// File: tb/oneshot_retrig_bench.sv
module oneshot_retrig_bench;
    import oneshot_pkg::*;

    localparam int W_W = 8;

    logic           clk = 1'b0;
    logic           rst;
    logic           ta, tb, cn;
    logic [W_W-1:0] wd;
    logic           q_f, qn_f, q_s, qn_s;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    oneshot_retrig #(.WIDTH_W(W_W), .MIN_GAP(4), .REM_DLY(3), .REL_MODE(REL_FIRES)) u_oneshot_retrig (
        .clk(clk), .rst(rst), .trig_a(ta), .trig_b(tb), .clr_n(cn), .width(wd), .q(q_f), .q_n(qn_f));

    oneshot_retrig #(.WIDTH_W(W_W), .MIN_GAP(4), .REM_DLY(3), .REL_MODE(REL_SILENT)) u_oneshot_retrig_silent (
        .clk(clk), .rst(rst), .trig_a(ta), .trig_b(tb), .clr_n(cn), .width(wd), .q(q_s), .q_n(qn_s));

    // Drive levels, wait wt falling edges, then expect q for each mode
    typedef struct packed {
        logic       a;
        logic       b;
        logic       r;
        logic [3:0] wt;
        logic       eq_fire;
        logic       eq_silent;
    } vec_t;

    localparam int NV = 30;
    localparam vec_t VEC [NV] = '{
        '{1'b1,1'b0,1'b1,4'd4,1'b0,1'b0}, //  0 R7 idle
        '{1'b1,1'b1,1'b1,4'd4,1'b0,1'b0}, //  1 R2 B rises with A high
        '{1'b0,1'b1,1'b1,4'd3,1'b1,1'b1}, //  2 R1 R10 A falls with B high
        '{1'b0,1'b1,1'b1,4'd4,1'b1,1'b1}, //  3 R5 last pulse cycle
        '{1'b0,1'b1,1'b1,4'd1,1'b0,1'b0}, //  4 R5 pulse over
        '{1'b0,1'b0,1'b1,4'd3,1'b0,1'b0}, //  5 R7 B falls
        '{1'b0,1'b1,1'b1,4'd3,1'b1,1'b1}, //  6 R2 B rises with A low
        '{1'b0,1'b0,1'b1,4'd1,1'b1,1'b1}, //  7
        '{1'b0,1'b1,1'b1,4'd4,1'b1,1'b1}, //  8 R5 retrigger extends
        '{1'b0,1'b1,1'b1,4'd3,1'b1,1'b1}, //  9
        '{1'b0,1'b1,1'b1,4'd1,1'b0,1'b0}, // 10 R5 full width after retrigger
        '{1'b1,1'b1,1'b1,4'd2,1'b0,1'b0}, // 11 R7 A rises
        '{1'b0,1'b1,1'b1,4'd1,1'b0,1'b0}, // 12
        '{1'b0,1'b0,1'b1,4'd1,1'b0,1'b0}, // 13
        '{1'b0,1'b1,1'b1,4'd1,1'b1,1'b1}, // 14 close retrigger
        '{1'b0,1'b1,1'b1,4'd4,1'b1,1'b1}, // 15
        '{1'b0,1'b1,1'b1,4'd1,1'b0,1'b0}, // 16 R6 close edge ignored
        '{1'b0,1'b0,1'b1,4'd2,1'b0,1'b0}, // 17
        '{1'b0,1'b1,1'b1,4'd4,1'b1,1'b1}, // 18
        '{1'b0,1'b1,1'b0,4'd2,1'b0,1'b0}, // 19 R3 clear cuts pulse
        '{1'b0,1'b0,1'b0,4'd2,1'b0,1'b0}, // 20 R3
        '{1'b0,1'b1,1'b0,4'd4,1'b0,1'b0}, // 21 R3 edge under clear ignored
        '{1'b0,1'b1,1'b1,4'd3,1'b1,1'b0}, // 22 R4 release fires / silent
        '{1'b0,1'b1,1'b1,4'd5,1'b0,1'b0}, // 23
        '{1'b0,1'b1,1'b0,4'd3,1'b0,1'b0}, // 24
        '{1'b1,1'b1,1'b1,4'd1,1'b0,1'b0}, // 25 release with A high
        '{1'b0,1'b1,1'b1,4'd4,1'b0,1'b0}, // 26 R12 edge in blind window
        '{1'b1,1'b1,1'b1,4'd1,1'b0,1'b0}, // 27
        '{1'b0,1'b1,1'b1,4'd3,1'b1,1'b1}, // 28 R12 edge after window
        '{1'b0,1'b1,1'b1,4'd5,1'b0,1'b0}  // 29
    };

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic chk_pair(input string tag, input logic exp_f, input logic exp_s);
        chk({tag, " q fire-mode"},   q_f,  exp_f);
        chk({tag, " q silent-mode"}, q_s,  exp_s);
        chk("R8 complement fire-mode",   qn_f, ~q_f);
        chk("R8 complement silent-mode", qn_s, ~q_s);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=hung expected=finished");
        finish_run();
    end

    initial begin
        rst = 1'b1; ta = 1'b1; tb = 1'b0; cn = 1'b1; wd = 8'd5;
        repeat (3) @(negedge clk);
        chk_pair("R11 reset state", 1'b0, 1'b0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            ta = VEC[i].a; tb = VEC[i].b; cn = VEC[i].r;
            repeat (int'(VEC[i].wt)) @(negedge clk);
            chk_pair($sformatf("vector %0d", i), VEC[i].eq_fire, VEC[i].eq_silent);
        end

        // R9: zero width gives no pulse
        wd = 8'd0; tb = 1'b0;
        repeat (6) @(negedge clk);
        tb = 1'b1;
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            chk_pair("R9 zero width", 1'b0, 1'b0);
        end

        // R9: width one gives a single cycle
        wd = 8'd1; tb = 1'b0;
        repeat (6) @(negedge clk);
        tb = 1'b1;
        repeat (3) @(negedge clk);
        chk_pair("R9 width one high", 1'b1, 1'b1);
        @(negedge clk);
        chk_pair("R9 width one low", 1'b0, 1'b0);

        // R11: reset in the middle of a pulse
        wd = 8'd5; tb = 1'b0;
        repeat (6) @(negedge clk);
        tb = 1'b1;
        repeat (4) @(negedge clk);
        chk_pair("R11 pulse before reset", 1'b1, 1'b1);
        rst = 1'b1;
        @(negedge clk);
        chk_pair("R11 reset ends pulse", 1'b0, 1'b0);
        rst = 1'b0;
        repeat (2) @(negedge clk);

        finish_run();
    end

endmodule